// File: doc/BRIEF.md
# Embedded Logic Analyzer Capture Core

This block records internal chip signals for later inspection. On every clock it can store one sample made of a 32-bit trigger word and a data word of configurable width into an on-chip trace memory. A 32-bit Wishbone slave drives it. Writing the compare value arms the core. It then fills the memory as a ring until the trigger word equals the compare value. After the match it records a programmed number of further samples and stops, so the memory holds the history around the event.

A programmable skip count lets the first matches pass without effect. The all-ones skip value means "never fire", so the ring keeps rolling. When the run is over, the host reads the trigger trace and the data trace, one 32-bit slice at a time, from a banked read map. The most significant data slice sits in the lowest data bank.

Top module: `trace_capture`

## Requirements
- R1: After reset the core is idle and stores nothing, `wb_ack_o` is low, the post-trigger count is 32 and the skip count is 0.
- R2: A bus write to word address 0 loads `wb_dat_i` as the compare value, copies the skip count into the working skip counter, clears the write pointer and starts logging from the next clock. This also applies while a run is in progress or already frozen. No sample is stored on the clock edge of that write.
- R3: On each logging clock the sample {trigger, data} is written at the write pointer. The pointer then steps by one and wraps modulo the memory depth (2^DEPTH_LOG2 entries).
- R4: A match is exact 32-bit equality of `trig_in` and the compare value. It is evaluated only while armed and not yet triggered. The matching sample is itself stored.
- R5: A write to word address 2 sets the skip count. A match while the working skip counter is nonzero decrements it instead of firing. The value 0xFFFFFFFF never fires and is never decremented.
- R6: A write to word address 1 sets the post-trigger count N, taken when the trigger fires. Exactly N more samples follow the trigger sample, then storing stops. If N = 0, the trigger sample is the last one.
- R7: Once stopped, the write pointer and the memory stay unchanged until address 0 is written again. Reads and writes to other addresses leave the capture state alone.
- R8: A read address splits into an entry index (low DEPTH_LOG2 bits) and a bank (the bits above). Bank 0 returns the stored trigger word. Bank b, for 1 ≤ b ≤ S with S = ceil(DATA_W/32), returns bits [(S-b)*32+31 : (S-b)*32] of the zero-padded data. Banks above S return 0.
- R9: A single-cycle strobe with `wb_cyc_i` high is acknowledged on the next clock with a one-cycle `wb_ack_o` pulse, and read data is valid with it. Writes to word addresses other than 0, 1 and 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 32 | Trigger word, sampled and compared |
| data_in | input | DATA_W | Data word, sampled |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Bus write enable |
| wb_adr_i | input | DEPTH_LOG2 + clog2(S+1) | Word address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Acknowledge |

## Verification
The bench builds the core with DATA_W = 40 and DEPTH_LOG2 = 6. That gives a 64-entry ring, which wraps within a few dozen cycles, and a default post-trigger count of 32, which is half the ring. With a 40-bit data word the top data slice is zero-padded and bank 3 lies outside the map, so the padding and the unmapped-bank reads are both exercised. A small trigger alphabet makes matches frequent, which drives the skip counter, immediate fires and post counts longer than the ring.

// File: rtl/trace_cap_pkg.sv
package trace_cap_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_ARMED = 2'd1,
    CAP_POST  = 2'd2,
    CAP_DONE  = 2'd3
  } cap_state_e;

  // number of 32-bit slices needed for a data word
  function automatic int slice_count(input int data_w);
    return (data_w + WORD_W - 1) / WORD_W;
  endfunction

  // bank field width: one trigger bank plus one bank per slice
  function automatic int bank_bits(input int data_w);
    return $clog2(slice_count(data_w) + 1);
  endfunction

  // skip counter step; all-ones is sticky
  function automatic logic [31:0] skip_step(input logic [31:0] cnt);
    return (cnt == 32'hFFFF_FFFF) ? cnt : cnt - 32'd1;
  endfunction

  // state after a fire, given the post-trigger count
  function automatic cap_state_e fire_target(input logic [31:0] post);
    return (post == 32'd0) ? CAP_DONE : CAP_POST;
  endfunction

endpackage

// File: rtl/tc_trigger.sv
module tc_trigger
  import trace_cap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        arm,
  input  logic [31:0] cmp_val,
  input  logic [31:0] skip_cfg,
  input  logic [31:0] post_cfg,
  input  logic [31:0] trig_in,
  output logic        cap_we,
  output logic        logging
);

  cap_state_e  state_q;
  logic [31:0] cmp_q;
  logic [31:0] skip_q;
  logic [31:0] left_q;

  logic match;
  logic skip_never;
  logic hit_skip;
  logic fire;

  assign match      = (state_q == CAP_ARMED) && (trig_in == cmp_q);
  assign skip_never = (skip_q == 32'hFFFF_FFFF);
  assign hit_skip   = match && (skip_q != 32'd0);
  assign fire       = match && (skip_q == 32'd0);
  assign logging    = (state_q == CAP_ARMED) || (state_q == CAP_POST);
  assign cap_we     = logging && !arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAP_IDLE;
      cmp_q   <= '0;
      skip_q  <= '0;
      left_q  <= '0;
    end else if (arm) begin
      state_q <= CAP_ARMED;
      cmp_q   <= cmp_val;
      skip_q  <= skip_cfg;
      left_q  <= '0;
    end else begin
      unique case (state_q)
        CAP_ARMED: begin
          if (hit_skip) begin
            skip_q <= skip_step(skip_q);
          end else if (fire) begin
            left_q  <= post_cfg;
            state_q <= fire_target(post_cfg);
          end
        end
        CAP_POST: begin
          left_q <= left_q - 32'd1;
          if (left_q == 32'd1) state_q <= CAP_DONE;
        end
        default: ;
      endcase
    end
  end

  AST_SKIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && skip_never) |=> (skip_q == 32'hFFFF_FFFF)); // R5

  AST_NEVER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && skip_never && state_q == CAP_ARMED) |=> (state_q == CAP_ARMED)); // R5

  AST_POST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && state_q == CAP_POST && left_q == 32'd1) |=> (state_q == CAP_DONE)); // R6

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && state_q == CAP_DONE) |=> (state_q == CAP_DONE)); // R7

endmodule

// File: rtl/tc_store.sv
module tc_store #(
  parameter int DATA_W     = 96,
  parameter int DEPTH_LOG2 = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  arm,
  input  logic                  cap_we,
  input  logic [31:0]           trig_in,
  input  logic [DATA_W-1:0]     data_in,
  input  logic                  rd_en,
  input  logic [DEPTH_LOG2-1:0] rd_idx,
  output logic [31:0]           rd_trig,
  output logic [DATA_W-1:0]     rd_data
);

  localparam int DEPTH   = 1 << DEPTH_LOG2;
  localparam int ENTRY_W = 32 + DATA_W;

  logic [ENTRY_W-1:0]    mem [DEPTH];
  logic [ENTRY_W-1:0]    rd_q;
  logic [DEPTH_LOG2-1:0] wptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wptr_q <= '0;
    else if (arm)    wptr_q <= '0;
    else if (cap_we) wptr_q <= wptr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (cap_we) mem[wptr_q] <= {trig_in, data_in};
    if (rd_en)  rd_q <= mem[rd_idx];
  end

  assign rd_trig = rd_q[ENTRY_W-1 -: 32];
  assign rd_data = rd_q[DATA_W-1:0];

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we |=> (wptr_q == $past(wptr_q) + 1'b1)); // R3

  AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_we && !arm) |=> $stable(wptr_q)); // R7

endmodule

// File: rtl/tc_bus.sv
module tc_bus
  import trace_cap_pkg::*;
#(
  parameter int DATA_W     = 96,
  parameter int DEPTH_LOG2 = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wb_cyc_i,
  input  logic                  wb_stb_i,
  input  logic                  wb_we_i,
  input  logic [DEPTH_LOG2+bank_bits(DATA_W)-1:0] wb_adr_i,
  input  logic [31:0]           wb_dat_i,
  output logic [31:0]           wb_dat_o,
  output logic                  wb_ack_o,
  input  logic [31:0]           rd_trig,
  input  logic [DATA_W-1:0]     rd_data,
  output logic                  arm,
  output logic [31:0]           cmp_val,
  output logic [31:0]           skip_cfg,
  output logic [31:0]           post_cfg,
  output logic                  rd_en,
  output logic [DEPTH_LOG2-1:0] rd_idx
);

  localparam int SL    = slice_count(DATA_W);
  localparam int BB    = bank_bits(DATA_W);
  localparam int NB    = 1 << BB;
  localparam int PADW  = SL * WORD_W;
  localparam int ADR_W = DEPTH_LOG2 + BB;

  logic          ack_q;
  logic          access;
  logic          wr;
  logic [BB-1:0] bank_q;
  logic [31:0]   post_q;
  logic [31:0]   skip_q;

  assign access  = wb_cyc_i && wb_stb_i && !ack_q;
  assign wr      = access && wb_we_i;
  assign arm     = wr && (wb_adr_i == ADR_W'(0));
  assign cmp_val = wb_dat_i;
  assign rd_en   = access && !wb_we_i;
  assign rd_idx  = wb_adr_i[DEPTH_LOG2-1:0];
  assign skip_cfg = skip_q;
  assign post_cfg = post_q;
  assign wb_ack_o = ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      bank_q <= '0;
      post_q <= 32'd32;
      skip_q <= 32'd0;
    end else begin
      ack_q <= access;
      if (rd_en) bank_q <= wb_adr_i[ADR_W-1:DEPTH_LOG2];
      if (wr && wb_adr_i == ADR_W'(1)) post_q <= wb_dat_i;
      if (wr && wb_adr_i == ADR_W'(2)) skip_q <= wb_dat_i;
    end
  end

  logic [PADW-1:0] padded;
  logic [31:0]     bank_word [NB];

  assign padded = PADW'(rd_data);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    if (b == 0) begin : g_trig
      assign bank_word[b] = rd_trig;
    end else if (b <= SL) begin : g_slice
      assign bank_word[b] = padded[(SL-b)*WORD_W +: WORD_W];
    end else begin : g_empty
      assign bank_word[b] = '0;
    end
  end

  assign wb_dat_o = bank_word[bank_q];

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q); // R9

  AST_ACK_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_i && wb_stb_i && !wb_ack_o) |=> wb_ack_o); // R9

endmodule

// File: rtl/trace_capture.sv
module trace_capture #(
  parameter int DATA_W     = 96,
  parameter int DEPTH_LOG2 = 10,
  localparam int ADR_W     = DEPTH_LOG2 + trace_cap_pkg::bank_bits(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       trig_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADR_W-1:0]  wb_adr_i,
  input  logic [31:0]       wb_dat_i,
  output logic [31:0]       wb_dat_o,
  output logic              wb_ack_o
);

  logic                  arm;
  logic [31:0]           cmp_val;
  logic [31:0]           skip_cfg;
  logic [31:0]           post_cfg;
  logic                  rd_en;
  logic [DEPTH_LOG2-1:0] rd_idx;
  logic [31:0]           rd_trig;
  logic [DATA_W-1:0]     rd_data;
  logic                  cap_we;
  logic                  logging;

  tc_bus #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
    .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i),
    .wb_dat_o(wb_dat_o), .wb_ack_o(wb_ack_o),
    .rd_trig(rd_trig), .rd_data(rd_data),
    .arm(arm), .cmp_val(cmp_val), .skip_cfg(skip_cfg), .post_cfg(post_cfg),
    .rd_en(rd_en), .rd_idx(rd_idx)
  );

  tc_trigger u_trig (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cmp_val(cmp_val),
    .skip_cfg(skip_cfg), .post_cfg(post_cfg), .trig_in(trig_in),
    .cap_we(cap_we), .logging(logging)
  );

  tc_store #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)) u_store (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cap_we(cap_we),
    .trig_in(trig_in), .data_in(data_in),
    .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_trig(rd_trig), .rd_data(rd_data)
  );

  AST_ARM_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (logging && cap_we == !arm)); // R2

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (!logging && !arm) |=> !cap_we); // R1

endmodule

// File: tb/sim_trace_capture.sv
module sim_trace_capture;

  localparam int DW  = 40;
  localparam int DL  = 6;
  localparam int DEP = 1 << DL;
  localparam int AW  = DL + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   trig_in = '0;
  logic [DW-1:0] data_in = '0;
  logic          wb_cyc_i = 1'b0, wb_stb_i = 1'b0, wb_we_i = 1'b0;
  logic [AW-1:0] wb_adr_i = '0;
  logic [31:0]   wb_dat_i = '0;
  logic [31:0]   wb_dat_o;
  logic          wb_ack_o;

  int checks = 0;
  int errors = 0;

  trace_capture #(.DATA_W(DW), .DEPTH_LOG2(DL)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .data_in(data_in),
    .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
    .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i),
    .wb_dat_o(wb_dat_o), .wb_ack_o(wb_ack_o)
  );

  always #10 clk = ~clk;

  // ---------------- reference model from the requirements ----------------
  int            m_st;          // 0 idle, 1 armed, 2 post, 3 stopped
  logic [31:0]   m_cmp, m_skip, m_skipcfg, m_post, m_left;
  logic [DL-1:0] m_ptr, m_fire_idx;
  logic [71:0]   m_mem [DEP];
  bit            m_val [DEP];
  logic [31:0]   m_exp;
  bit            m_expv;

  function automatic logic [31:0] exp_word(input logic [71:0] ent, input int bank);
    logic [63:0] pad;
    pad = {24'd0, ent[39:0]};
    if (bank == 0) return ent[71:40];
    if (bank == 1) return pad[63:32];
    if (bank == 2) return pad[31:0];
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cmp = 0; m_skip = 0; m_skipcfg = 0; m_post = 32; m_left = 0;
      m_ptr = 0; m_fire_idx = 0; m_expv = 0; m_exp = 0;
      for (int i = 0; i < DEP; i++) m_val[i] = 0;
    end else begin
      bit acc, armw, stored;
      acc  = wb_cyc_i && wb_stb_i;
      armw = acc && wb_we_i && wb_adr_i == 0;
      if (acc && !wb_we_i) begin
        m_expv = m_val[wb_adr_i[DL-1:0]];
        m_exp  = exp_word(m_mem[wb_adr_i[DL-1:0]], int'(wb_adr_i[AW-1:DL]));
      end
      stored = (m_st == 1 || m_st == 2) && !armw;
      if (stored) begin
        m_mem[m_ptr] = {trig_in, data_in};
        m_val[m_ptr] = 1;
      end
      if (armw) begin
        m_st = 1; m_cmp = wb_dat_i; m_skip = m_skipcfg; m_ptr = 0;
      end else begin
        if (m_st == 1 && trig_in == m_cmp) begin
          if (m_skip == 32'hFFFF_FFFF) ;
          else if (m_skip != 0) m_skip = m_skip - 1;
          else begin
            m_fire_idx = m_ptr; m_left = m_post;
            m_st = (m_post == 0) ? 3 : 2;
          end
        end else if (m_st == 2) begin
          m_left = m_left - 1;
          if (m_left == 0) m_st = 3;
        end
        if (stored) m_ptr = m_ptr + 1'b1;
      end
      if (acc && wb_we_i && wb_adr_i == 1) m_post = wb_dat_i;
      if (acc && wb_we_i && wb_adr_i == 2) m_skipcfg = wb_dat_i;
    end
  end

  // ---------------- stimulus pattern driver ----------------
  int          pat_mod = 4;
  bit          pat_const = 0;
  logic [31:0] pat_val = 0;
  bit          inj_req = 0;
  logic [31:0] inj_val = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        data_in <= {$urandom, $urandom} & {DW{1'b1}};
        if (inj_req) begin
          trig_in <= inj_val; inj_req = 0;
        end else if (pat_const) trig_in <= pat_val;
        else trig_in <= $urandom % pat_mod;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wb_cyc_i = 1; wb_stb_i = 1; wb_we_i = 1; wb_adr_i = a; wb_dat_i = d;
    @(negedge clk);
    wb_cyc_i = 0; wb_stb_i = 0; wb_we_i = 0;
    check(wb_ack_o == 1'b1, "R9 ack after write", {31'd0, wb_ack_o}, 32'd1);
    @(negedge clk);
    check(wb_ack_o == 1'b0, "R9 ack one cycle", {31'd0, wb_ack_o}, 32'd0);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    wb_cyc_i = 1; wb_stb_i = 1; wb_we_i = 0; wb_adr_i = a;
    @(negedge clk);
    wb_cyc_i = 0; wb_stb_i = 0;
    check(wb_ack_o == 1'b1, "R9 ack after read", {31'd0, wb_ack_o}, 32'd1);
    if (m_expv) check(wb_dat_o == m_exp, req, wb_dat_o, m_exp);
    @(negedge clk);
  endtask

  task automatic dump(input string req);
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < DEP; i++)
        bus_read(AW'((b << DL) | i), req);
  endtask

  task automatic wait_stop(input int maxc);
    for (int c = 0; c < maxc && m_st != 3; c++) @(negedge clk);
  endtask

  initial begin
    repeat (20000000) @(posedge clk);
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(wb_ack_o == 1'b0, "R1 ack low in reset", {31'd0, wb_ack_o}, 32'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(wb_ack_o == 1'b0, "R1 ack low after reset", {31'd0, wb_ack_o}, 32'd0);

    // R1 R4 R6: default post count 32, single injected match
    pat_mod = 4; pat_const = 0;
    bus_write(0, 32'h0000_00A5);
    repeat (20) @(negedge clk);
    inj_val = 32'hA5; inj_req = 1;
    wait_stop(200);
    check(m_st == 3, "R1 default post stop", m_st, 3);
    bus_read(AW'(m_fire_idx), "R4 trigger sample stored");
    check(wb_dat_o == 32'hA5, "R4 trigger word at fire index", wb_dat_o, 32'hA5);
    dump("R3 R8 R1 default run contents");

    // R7: stays frozen with inputs moving, other writes ignored
    repeat (80) @(negedge clk);
    bus_write(3, 32'h0000_0000);
    bus_write(AW'(1 << DL), 32'h0000_0000);
    bus_write(AW'(3 << DL), 32'h0000_0001);
    dump("R7 R9 frozen after other writes");

    // R5: skip count with frequent matches
    bus_write(2, 32'd3);
    bus_write(1, 32'd5);
    pat_mod = 8;
    bus_write(0, 32'd7);
    wait_stop(3000);
    dump("R5 skip then fire");

    // R6: post count zero
    bus_write(2, 32'd0);
    bus_write(1, 32'd0);
    bus_write(0, 32'd2);
    wait_stop(3000);
    dump("R6 post zero");

    // R5: sticky never-fire value with constant matching trigger
    bus_write(2, 32'hFFFF_FFFF);
    bus_write(1, 32'd4);
    pat_const = 1; pat_val = 32'd3;
    bus_write(0, 32'd3);
    repeat (150) @(negedge clk);
    dump("R5 never fire keeps wrapping");
    // R2: rearm while logging, skip zero -> fires at once
    bus_write(2, 32'd0);
    bus_write(0, 32'd3);
    wait_stop(100);
    check(m_fire_idx == 0, "R2 first sample after rearm", {26'd0, m_fire_idx}, 32'd0);
    dump("R2 R6 rearm immediate fire");
    pat_const = 0;

    // random rounds, including post count beyond the ring
    for (int r = 0; r < 5; r++) begin
      bus_write(2, $urandom % 3);
      bus_write(1, (r == 4) ? 32'd100 : ($urandom % 40));
      pat_mod = 6;
      bus_write(0, $urandom % 6);
      wait_stop(4000);
      dump("R3 R5 R6 R8 random round");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule